// File: doc/BRIEF.md
# Scan Chain with Frozen Functional Outputs

This block is a parameterised chain of mux-type scan flip-flops. Each flip-flop feeds a second register, the hold stage. The hold stage drives the functional output that the logic downstream sees. In functional mode every stage captures its own data bit. In shift mode the chain moves serially from one stage to the next, and the last stage leaves the block as a serial scan output.

A common hold control freezes all functional outputs at the values they had when the hold was raised. While the outputs are frozen, the internal chain can keep shifting. The logic driven by the outputs therefore does not toggle during scan loading. This also isolates any asynchronous parts of that logic from the shifting pattern.

The serial path always runs through the internal flip-flops, never through the frozen outputs. For this reason a load under hold still delivers the scan stream intact. Reset is synchronous and clears both register ranks. The scan and hold controls are plain level inputs with no handshake. The chain accepts one serial bit on every clock edge while shift mode is set, and applies no back-pressure.

Top module: `scan_hold_chain`

## Requirements
- R1: With `rst` high at a rising edge, every internal flip-flop and every held output becomes 0. After that edge, `held_q` reads all zeros and `scan_out` reads 0.
- R2: With `scan_en` low, stage i loads `func_d[i]` at each rising edge.
- R3: With `scan_en` high, stage 0 loads `scan_in` and stage i (for i > 0) loads the internal value of stage i-1 at each rising edge. In this mode `func_d` has no effect.
- R4: `scan_out` always equals the internal value of the last stage, index `CHAIN_LEN-1`.
- R5: At any rising edge where `hold_en` is high and `rst` is low, `held_q` keeps its value, whatever the internal stages do at that edge.
- R6: At any rising edge where `hold_en` is low and `rst` is low, `held_q[i]` takes the same value that internal stage i loads at that edge. After the edge, the held outputs therefore equal the internal state.
- R7: After a functional load of pattern P, shifting under hold gives `scan_out` = P[CHAIN_LEN-1-s] after s shifts, for s < CHAIN_LEN. After that it gives the `scan_in` bit applied at shift s-CHAIN_LEN+1. Throughout, `held_q` stays at P.
- R8: Reset takes priority over hold. A rising edge with both `rst` and `hold_en` high clears `held_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | 1 = shift mode, 0 = functional capture |
| hold_en | input | 1 | 1 = freeze the held outputs |
| scan_in | input | 1 | Serial data into stage 0 |
| func_d | input | CHAIN_LEN | Functional data, bit i to stage i |
| held_q | output | CHAIN_LEN | Held functional outputs, bit i from stage i |
| scan_out | output | 1 | Internal value of the last stage |

## Verification
Both outputs come straight from registers, so every result is due exactly one rising edge after the inputs that caused it. The bench changes inputs on the falling edge. It advances its queue-based reference model on the next rising edge and compares `held_q` and `scan_out` on the falling edge that follows, so every comparison happens one full edge after its stimulus. During the shift under hold, the scan-out stream is also checked against the order the pattern was loaded and streamed. After each edge the held outputs are checked against a snapshot taken before the shift began.

// File: rtl/shc_pkg.sv
package shc_pkg;

  // Source selected by the input multiplexer of each scan cell.
  typedef enum logic {
    SRC_FUNC  = 1'b0,
    SRC_SHIFT = 1'b1
  } shc_src_e;

endpackage

// File: rtl/shc_scan_cell.sv
module shc_scan_cell
  import shc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  shc_src_e src_sel,
  input  logic     func_d,
  input  logic     scan_d,
  output logic     d_next,
  output logic     q
);

  // Input multiplexer: functional bit or the serial link from the previous stage.
  always_comb begin
    unique case (src_sel)
      SRC_SHIFT: d_next = scan_d;
      default:   d_next = func_d;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d_next;
  end

  // R1: reset clears the internal flip-flop.
  assert_cell_reset_R1: assert property (@(posedge clk) rst |=> (q == 1'b0));

  // R2: functional capture.
  assert_cell_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (src_sel == SRC_FUNC) |=> (q == $past(func_d)));

  // R3: shift from the serial link.
  assert_cell_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (src_sel == SRC_SHIFT) |=> (q == $past(scan_d)));

endmodule

// File: rtl/shc_hold_cell.sv
module shc_hold_cell (
  input  logic clk,
  input  logic rst,
  input  logic hold_en,
  input  logic d_next,
  input  logic ff_q,
  output logic held_q
);

  // Loads the same next value as its scan cell, so it tracks that cell
  // edge for edge whenever the hold is released.
  always_ff @(posedge clk) begin
    if (rst)           held_q <= 1'b0;
    else if (!hold_en) held_q <= d_next;
  end

  // R5: frozen under hold.
  assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    hold_en |=> $stable(held_q));

  // R6: matches the internal flip-flop after an unheld edge.
  assert_hold_follow_R6: assert property (@(posedge clk) disable iff (rst)
    !hold_en |=> (held_q == ff_q));

  // R8: reset wins over hold.
  assert_hold_reset_R8: assert property (@(posedge clk)
    (rst && hold_en) |=> (held_q == 1'b0));

endmodule

// File: rtl/scan_hold_chain.sv
module scan_hold_chain
  import shc_pkg::*;
#(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scan_en,
  input  logic                 hold_en,
  input  logic                 scan_in,
  input  logic [CHAIN_LEN-1:0] func_d,
  output logic [CHAIN_LEN-1:0] held_q,
  output logic                 scan_out
);

  localparam int LAST = CHAIN_LEN - 1;

  shc_src_e             src_sel;
  logic [CHAIN_LEN-1:0] link;
  logic [CHAIN_LEN-1:0] d_next;
  logic [CHAIN_LEN-1:0] ff_q;

  assign src_sel = scan_en ? SRC_SHIFT : SRC_FUNC;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign link[i] = scan_in;
    end else begin : g_body
      assign link[i] = ff_q[i-1];
    end

    shc_scan_cell u_scan (
      .clk     (clk),
      .rst     (rst),
      .src_sel (src_sel),
      .func_d  (func_d[i]),
      .scan_d  (link[i]),
      .d_next  (d_next[i]),
      .q       (ff_q[i])
    );

    shc_hold_cell u_hold (
      .clk     (clk),
      .rst     (rst),
      .hold_en (hold_en),
      .d_next  (d_next[i]),
      .ff_q    (ff_q[i]),
      .held_q  (held_q[i])
    );
  end

  assign scan_out = ff_q[LAST];

  // R7: the serial path runs through the internal flip-flops, so a shifted
  // bit reaches the last stage even while the held outputs stay frozen.
  assert_chain_tail_R7: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> (scan_out == $past(ff_q[LAST-1])));

endmodule

// File: tb/scan_hold_chain_bench.sv
module scan_hold_chain_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst, scan_en, hold_en, scan_in;
  logic [N-1:0] func_d;
  logic [N-1:0] held_q;
  logic         scan_out;

  scan_hold_chain #(.CHAIN_LEN(N)) u_scan_hold_chain (
    .clk(clk), .rst(rst), .scan_en(scan_en), .hold_en(hold_en),
    .scan_in(scan_in), .func_d(func_d), .held_q(held_q), .scan_out(scan_out)
  );

  bit           model_q[$];
  logic [N-1:0] model_h;
  int           vectors = 0;
  int           errs = 0;
  bit           done = 1'b0;

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = model_q[i];
    return v;
  endfunction

  task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < N; i++) model_q[i] = 1'b0;
      model_h = '0;
    end else begin
      if (scan_en) begin
        model_q.push_front(scan_in);
        void'(model_q.pop_back());
      end else begin
        for (int i = 0; i < N; i++) model_q[i] = func_d[i];
      end
      if (!hold_en) model_h = model_vec();
    end
    @(negedge clk);
    check(tag, "held_q", held_q, model_h);
    check({tag, "/R4"}, "scan_out", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, model_q[N-1]});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat;
    logic [N-1:0] snap;
    logic [15:0]  stream;
    for (int i = 0; i < N; i++) model_q.push_back(1'b0);
    model_h = '0;
    rst = 1'b1; scan_en = 1'b0; hold_en = 1'b0; scan_in = 1'b0; func_d = '1;
    tick("R1");
    tick("R1");
    check("R1", "held_q after reset", held_q, '0);
    rst = 1'b0;

    // R2 / R6: functional capture, held outputs follow.
    foreach (pat[j]) pat[j] = 1'b0;
    for (int k = 0; k < 6; k++) begin
      func_d = (k == 0) ? 8'hA5 : (k == 1) ? 8'h5A : (k == 2) ? 8'hFF : N'($urandom);
      tick("R2");
    end

    // R7 / R5: load pattern, then shift under hold.
    pat = 8'hC6;
    func_d = pat;
    tick("R2");
    stream = 16'hB38D;
    hold_en = 1'b1; scan_en = 1'b1;
    snap = held_q;
    check("R7", "loaded pattern", snap, pat);
    for (int s = 1; s <= N + 6; s++) begin
      logic exp_bit;
      scan_in = stream[s-1];
      func_d  = N'($urandom);
      tick("R3");
      check("R5", "held_q frozen", held_q, snap);
      exp_bit = (s < N) ? pat[N-1-s] : stream[s-N];
      check("R7", "scan_out stream", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, exp_bit});
    end

    // R6: release hold while shifting, outputs now follow.
    hold_en = 1'b0;
    for (int s = 0; s < 4; s++) begin
      scan_in = s[0];
      tick("R6");
    end
    scan_en = 1'b0;
    func_d = 8'h3C;
    tick("R6");
    check("R6", "held_q follows capture", held_q, 8'h3C);

    // R5 with functional capture under hold.
    hold_en = 1'b1;
    func_d = 8'h81;
    tick("R5");
    check("R5", "held_q frozen on capture", held_q, 8'h3C);

    // R8: reset beats hold.
    rst = 1'b1;
    tick("R8");
    check("R8", "held_q cleared under hold", held_q, '0);
    rst = 1'b0; hold_en = 1'b0;
    func_d = 8'h77;
    tick("R2");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule